// File: doc/BRIEF.md
# PCI Burst Address Sequencer

This block generates the double-word address for every data phase of a PCI burst, on either the initiator or the target side. A start strobe captures the first address together with the burst settings: ordering, cache line size, phase width, coherency and the last address the device decodes. Each advance strobe marks a completed data phase and moves the address to the next double word in the chosen ordering. A disconnect flag tells the bus logic to end the burst once the phase now in progress completes.

Three orderings are available. Linear steps upward. Wrap stays inside one cache line and returns to the line's first word. Toggle combines the first address with a running count by exclusive-or. A 64-bit phase carries two double words, so every ordering moves by two per phase. The flag is computed from registered state only. It therefore never changes in the middle of a phase. It changes only after a strobe.

Top module: `pci_burst_addr_seq`

## Requirements
- R1: After reset, addr_o is 0 and disc_o is 0. The reset settings are linear ordering, 32-bit phases, coherency off and an all-ones limit.
- R2: When start_i is high, the next clock loads addr_o with base_i, clears the phase counter and captures mode_i, line_i, wide_i, coh_i and limit_i. If start_i and advance_i are both high, start_i takes priority.
- R3: If neither strobe is high, addr_o and disc_o keep their values.
- R4: With mode 2'b00 (linear) and 32-bit phases, each advance adds 1 to addr_o.
- R5: With wide_i captured high (64-bit phases), each advance moves the ordering by 2 double words: linear adds 2, wrap adds 2 inside the line, and the toggle counter grows by 2.
- R6: With mode 2'b10 (wrap) and a valid line size L, each advance changes only the low log2(L) bits, computing (addr+step) mod L. The upper bits stay the same.
- R7: With mode 2'b01 (toggle), addr_o equals the start address XOR the number of double words already transferred.
- R8: A valid line size is a power of two from 4 to 128 double words. Any other value makes wrap behave like linear and turns off the coherency check.
- R9: With coherency on, a valid line and linear or wrap ordering, disc_o is high while the current phase covers the last double word of its cache line.
- R10: disc_o is high while the address that would follow the current phase exceeds the captured limit. This includes a linear address that overflows.
- R11: Mode 2'b11 is reserved. While it is captured, disc_o is high from the first phase on.
- R12: With 64-bit phases and an odd start double word (not 8-byte aligned), disc_o is high from the first phase on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst and capture the settings |
| base_i | input | ADDR_W | First double-word address |
| mode_i | input | 2 | Ordering: 00 linear, 01 toggle, 10 wrap, 11 reserved |
| line_i | input | LINE_W | Cache line size in double words |
| wide_i | input | 1 | 64-bit data phases |
| coh_i | input | 1 | Disconnect at cache-line ends |
| limit_i | input | ADDR_W | Highest double-word address the device decodes |
| advance_i | input | 1 | A data phase completed |
| addr_o | output | ADDR_W | Double-word address of the current phase |
| disc_o | output | 1 | End the burst after the current phase |

## Verification
The bench drives wrap bursts that begin in the middle of a line. A design that wraps at the wrong bit would spill into the next line or jump back too early. It runs toggle bursts in both phase widths, which expose a counter that steps by one instead of two. It also checks that a non-power-of-two line size turns wrap into linear. The disconnect corners are the last word of a line with and without 64-bit pairing, the word exactly at the limit, the reserved mode and an odd 64-bit start. Flagging one phase too early or too late shows up as a mismatch at that address. A start that arrives together with an advance checks that the load takes priority.

// File: rtl/pbas_pkg.sv
package pbas_pkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_TOGGLE = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_RSVD   = 2'b11
  } order_e;
endpackage

// File: rtl/pbas_line_decode.sv
module pbas_line_decode #(
  parameter int ADDR_W = 30,
  parameter int LINE_W = 8
) (
  input  logic [LINE_W-1:0] line_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int MIN_LOG = 2;
  localparam int MAX_LOG = 7;

  always_comb begin
    ok_o = 1'b0;
    for (int k = MIN_LOG; k <= MAX_LOG; k++) begin
      if (line_i == LINE_W'(1 << k)) ok_o = 1'b1;
    end
    mask_o = ok_o ? (ADDR_W'(line_i) - ADDR_W'(1)) : '0;
  end
endmodule

// File: rtl/pbas_next_addr.sv
module pbas_next_addr
  import pbas_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] cnt_i,
  input  order_e            mode_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              line_ok_i,
  input  logic              wide_i,
  output logic [ADDR_W:0]   nxt_ext_o,
  output logic [ADDR_W-1:0] nxt_cnt_o
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W:0]   sum_ext;
  logic [ADDR_W-1:0] wrap_val;

  always_comb begin
    step      = wide_i ? ADDR_W'(2) : ADDR_W'(1);
    sum_ext   = {1'b0, addr_i} + {1'b0, step};
    nxt_cnt_o = cnt_i + step;
    wrap_val  = (addr_i & ~mask_i) | (sum_ext[ADDR_W-1:0] & mask_i);
    case (mode_i)
      ORD_WRAP:   nxt_ext_o = line_ok_i ? {1'b0, wrap_val} : sum_ext;
      ORD_TOGGLE: nxt_ext_o = {1'b0, base_i ^ nxt_cnt_o};
      default:    nxt_ext_o = sum_ext;
    endcase
  end
endmodule

// File: rtl/pbas_disc.sv
module pbas_disc
  import pbas_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W:0]   nxt_ext_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  order_e            mode_i,
  input  logic              wide_i,
  input  logic              base_odd_i,
  input  logic              coh_i,
  input  logic              line_ok_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              disc_o
);
  logic last_in_line;
  logic coh_hit;
  logic lim_hit;
  logic cfg_bad;

  always_comb begin
    last_in_line = ((addr_i | ADDR_W'(wide_i)) & mask_i) == mask_i;
    coh_hit      = coh_i && line_ok_i &&
                   (mode_i == ORD_LINEAR || mode_i == ORD_WRAP) && last_in_line;
    lim_hit      = nxt_ext_i > {1'b0, limit_i};
    cfg_bad      = (mode_i == ORD_RSVD) || (wide_i && base_odd_i);
    disc_o       = cfg_bad || coh_hit || lim_hit;
  end
endmodule

// File: rtl/pci_burst_addr_seq.sv
module pci_burst_addr_seq
  import pbas_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        mode_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              wide_i,
  input  logic              coh_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              disc_o
);
  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // state
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] limit_q, limit_d;
  logic [ADDR_W-1:0] mask_q, mask_d;
  order_e            mode_q, mode_d;
  logic              line_ok_q, line_ok_d;
  logic              wide_q, wide_d;
  logic              coh_q, coh_d;
  logic              upd_en;

  logic              dec_ok;
  logic [ADDR_W-1:0] dec_mask;
  logic [ADDR_W:0]   nxt_ext;
  logic [ADDR_W-1:0] nxt_cnt;

  pbas_line_decode #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_line (
    .line_i (line_i),
    .ok_o   (dec_ok),
    .mask_o (dec_mask)
  );

  pbas_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .addr_i    (addr_q),
    .base_i    (base_q),
    .cnt_i     (cnt_q),
    .mode_i    (mode_q),
    .mask_i    (mask_q),
    .line_ok_i (line_ok_q),
    .wide_i    (wide_q),
    .nxt_ext_o (nxt_ext),
    .nxt_cnt_o (nxt_cnt)
  );

  pbas_disc #(.ADDR_W(ADDR_W)) u_disc (
    .addr_i     (addr_q),
    .nxt_ext_i  (nxt_ext),
    .limit_i    (limit_q),
    .mode_i     (mode_q),
    .wide_i     (wide_q),
    .base_odd_i (base_q[0]),
    .coh_i      (coh_q),
    .line_ok_i  (line_ok_q),
    .mask_i     (mask_q),
    .disc_o     (disc_o)
  );

  // next state
  always_comb begin
    upd_en    = start_i || advance_i;
    addr_d    = addr_q;
    base_d    = base_q;
    cnt_d     = cnt_q;
    limit_d   = limit_q;
    mask_d    = mask_q;
    mode_d    = mode_q;
    line_ok_d = line_ok_q;
    wide_d    = wide_q;
    coh_d     = coh_q;
    if (start_i) begin
      addr_d    = base_i;
      base_d    = base_i;
      cnt_d     = '0;
      limit_d   = limit_i;
      mask_d    = dec_mask;
      mode_d    = order_e'(mode_i);
      line_ok_d = dec_ok;
      wide_d    = wide_i;
      coh_d     = coh_i;
    end else if (advance_i) begin
      addr_d = nxt_ext[ADDR_W-1:0];
      cnt_d  = nxt_cnt;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q    <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      limit_q   <= '1;
      mask_q    <= '0;
      mode_q    <= ORD_LINEAR;
      line_ok_q <= 1'b0;
      wide_q    <= 1'b0;
      coh_q     <= 1'b0;
    end else if (upd_en) begin
      addr_q    <= addr_d;
      base_q    <= base_d;
      cnt_q     <= cnt_d;
      limit_q   <= limit_d;
      mask_q    <= mask_d;
      mode_q    <= mode_d;
      line_ok_q <= line_ok_d;
      wide_q    <= wide_d;
      coh_q     <= coh_d;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pbas_checker.sv
module pbas_checker #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              start_i,
  input logic              advance_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              disc_o,
  input logic [1:0]        mode_q,
  input logic              wide_q,
  input logic              line_ok_q,
  input logic [ADDR_W-1:0] mask_q
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> addr_o == $past(base_i));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && !advance_i) |=> ($stable(addr_o) && $stable(disc_o)));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && advance_i && mode_q == 2'b00 && !wide_q)
      |=> addr_o == $past(addr_o) + ADDR_W'(1));

  assert_wide_step_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && advance_i && mode_q == 2'b00 && wide_q)
      |=> addr_o == $past(addr_o) + ADDR_W'(2));

  assert_wrap_line_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && advance_i && mode_q == 2'b10 && line_ok_q)
      |=> (addr_o & ~$past(mask_q)) == ($past(addr_o) & ~$past(mask_q)));

  assert_reserved_disc_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == 2'b11) |-> disc_o);
endmodule

bind pci_burst_addr_seq pbas_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start_i    (start_i),
  .advance_i  (advance_i),
  .base_i     (base_i),
  .addr_o     (addr_o),
  .disc_o     (disc_o),
  .mode_q     (mode_q),
  .wide_q     (wide_q),
  .line_ok_q  (line_ok_q),
  .mask_q     (mask_q)
);

// File: tb/pci_burst_addr_seq_test.sv
`timescale 1ns/1ps
module pci_burst_addr_seq_test;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, wide_i, coh_i, advance_i;
  logic [AW-1:0] base_i, limit_i;
  logic [1:0]    mode_i;
  logic [7:0]    line_i;
  logic [AW-1:0] addr_o;
  logic          disc_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_burst_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .mode_i(mode_i), .line_i(line_i), .wide_i(wide_i), .coh_i(coh_i),
    .limit_i(limit_i), .advance_i(advance_i), .addr_o(addr_o), .disc_o(disc_o)
  );

  // reference model state
  logic [AW-1:0] m_addr, m_base, m_cnt, m_lim;
  logic [1:0]    m_mode;
  logic [7:0]    m_line;
  logic          m_wide, m_coh;

  logic [AW-1:0] q_addr[$];
  logic          q_disc[$];
  string         q_req[$];

  function automatic bit line_valid(input logic [7:0] l);
    return l == 8'd4 || l == 8'd8 || l == 8'd16 || l == 8'd32 || l == 8'd64 || l == 8'd128;
  endfunction

  function automatic logic [AW:0] m_next();
    logic [AW-1:0] s = m_wide ? AW'(2) : AW'(1);
    logic [AW-1:0] mk = AW'(m_line) - AW'(1);
    logic [AW:0]   lin = {1'b0, m_addr} + {1'b0, s};
    if (m_mode == 2'b01) return {1'b0, m_base ^ (m_cnt + s)};
    if (m_mode == 2'b10 && line_valid(m_line))
      return {1'b0, (m_addr & ~mk) | (lin[AW-1:0] & mk)};
    return lin;
  endfunction

  function automatic logic m_disc();
    logic [AW-1:0] mk = AW'(m_line) - AW'(1);
    logic [AW-1:0] last = m_addr + (m_wide ? AW'(1) : AW'(0));
    logic d = 1'b0;
    if (m_mode == 2'b11) d = 1'b1;
    if (m_wide && m_base[0]) d = 1'b1;
    if (m_next() > {1'b0, m_lim}) d = 1'b1;
    if (m_coh && line_valid(m_line) && (m_mode == 2'b00 || m_mode == 2'b10)
        && (last & mk) == mk) d = 1'b1;
    return d;
  endfunction

  task automatic op(input logic st, input logic adv, input string req);
    logic [AW:0] nx;
    @(negedge clk);
    start_i = st;
    advance_i = adv;
    if (st) begin
      m_addr = base_i; m_base = base_i; m_cnt = '0; m_lim = limit_i;
      m_mode = mode_i; m_line = line_i; m_wide = wide_i; m_coh = coh_i;
    end else if (adv) begin
      nx = m_next();
      m_cnt = m_cnt + (m_wide ? AW'(2) : AW'(1));
      m_addr = nx[AW-1:0];
    end
    q_addr.push_back(m_addr);
    q_disc.push_back(m_disc());
    q_req.push_back(req);
  endtask

  task automatic burst(input logic [AW-1:0] b, input logic [1:0] md, input logic [7:0] ln,
                       input logic w, input logic c, input logic [AW-1:0] lim,
                       input int phases, input string req);
    base_i = b; mode_i = md; line_i = ln; wide_i = w; coh_i = c; limit_i = lim;
    op(1'b1, 1'b0, req);
    for (int i = 0; i < phases; i++) op(1'b0, 1'b1, req);
  endtask

  // monitor: compare after each clock edge
  always @(posedge clk) begin
    #1;
    if (q_addr.size() > 0) begin
      logic [AW-1:0] ea;
      logic ed;
      string rq;
      ea = q_addr.pop_front();
      ed = q_disc.pop_front();
      rq = q_req.pop_front();
      n_cmp++;
      if (addr_o !== ea || disc_o !== ed) begin
        n_bad++;
        $display("FAIL %s: addr=%h disc=%b expected addr=%h disc=%b", rq, addr_o, disc_o, ea, ed);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; advance_i = 1'b0; base_i = '0; mode_i = 2'b00;
    line_i = 8'd8; wide_i = 1'b0; coh_i = 1'b0; limit_i = '1;
    m_addr = '0; m_base = '0; m_cnt = '0; m_lim = '1; m_mode = 2'b00;
    m_line = 8'd0; m_wide = 1'b0; m_coh = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (addr_o !== '0 || disc_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: addr=%h disc=%b expected addr=0 disc=0", addr_o, disc_o);
    end
    // R4 linear 32-bit
    burst(30'h10, 2'b00, 8'd8, 1'b0, 1'b0, '1, 5, "R4");
    // R3 idle holds
    for (int i = 0; i < 3; i++) op(1'b0, 1'b0, "R3");
    // R5 linear 64-bit
    burst(30'h40, 2'b00, 8'd8, 1'b1, 1'b0, '1, 4, "R5");
    // R6 wrap from middle of an 8-word line
    burst(30'h1D, 2'b10, 8'd8, 1'b0, 1'b0, '1, 6, "R6");
    // R6 wrap 64-bit, 4-word line
    burst(30'h52, 2'b10, 8'd4, 1'b1, 1'b0, '1, 4, "R6_wide");
    // R6 wrap 128-word line
    burst(30'h17E, 2'b10, 8'd128, 1'b0, 1'b0, '1, 4, "R6_big");
    // R7 toggle 32-bit
    burst(30'h5, 2'b01, 8'd8, 1'b0, 1'b0, '1, 6, "R7");
    // R7 toggle 64-bit (R5 counter step)
    burst(30'h8, 2'b01, 8'd8, 1'b1, 1'b0, '1, 5, "R7_R5");
    // R8 invalid line size behaves linear, no coherency stop
    burst(30'h1D, 2'b10, 8'd6, 1'b0, 1'b1, '1, 5, "R8");
    // R9 coherency stop in linear and wrap
    burst(30'h21, 2'b00, 8'd4, 1'b0, 1'b1, '1, 4, "R9");
    burst(30'h34, 2'b00, 8'd8, 1'b1, 1'b1, '1, 3, "R9_wide");
    burst(30'h2E, 2'b10, 8'd16, 1'b0, 1'b1, '1, 3, "R9_wrap");
    // R10 limit, including top-of-space overflow
    burst(30'hFE, 2'b00, 8'd8, 1'b0, 1'b0, 30'h100, 3, "R10");
    burst(30'h3FFF_FFFE, 2'b00, 8'd8, 1'b0, 1'b0, '1, 2, "R10_top");
    // R11 reserved mode
    burst(30'h60, 2'b11, 8'd8, 1'b0, 1'b0, '1, 1, "R11");
    // R12 misaligned 64-bit start
    burst(30'h71, 2'b00, 8'd8, 1'b1, 1'b0, '1, 1, "R12");
    burst(30'h70, 2'b00, 8'd8, 1'b1, 1'b0, '1, 1, "R12_aligned");
    // R2 start wins over advance
    base_i = 30'h200; mode_i = 2'b00; line_i = 8'd8; wide_i = 1'b0; coh_i = 1'b0; limit_i = '1;
    op(1'b0, 1'b1, "R2");
    op(1'b1, 1'b1, "R2");
    op(1'b0, 1'b1, "R2");
    op(1'b0, 1'b0, "R2");
    @(negedge clk);
    start_i = 1'b0; advance_i = 1'b0;
    while (q_addr.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule